// File: doc/BRIEF.md
# Always-On Wake and Event Controller

This controller lives in the always-on part of a chip and decides when the main power domain may leave its low-power state. It watches an external wake pin, a compare strobe from a real-time counter, a low-battery flag and a supply-good indication. All of its state advances on a slow module tick. That tick comes either straight from a 32.768 kHz reference, or from a fast crystal-rate clock divided by a parameter that defaults to 128.

Software asks for low power by writing a sleep command. A wake-pin edge or a real-time-counter match then powers the main domain up again and keeps its reset asserted until supply-good is seen. The controller records which event caused the wake, and those records survive the main-domain reset. Three raw status bits are combined with a mask register to give a masked status. The masked bits are ORed into one interrupt line, and pending bits are cleared by writing ones to a clear register.

Register writes are captured from the bus side and take effect only on the next module tick.

Top module: `wake_ctrl`

## Requirements
- R1: After `rst_n` is released, `raw_stat`, `mask_reg`, `mask_stat`, `irq` and `clk_sel` are 0, `main_pwr_en` is 1 and `main_rst_n` is 0.
- R2: A write to address 2 with data bit 1 set, made while the main domain is running, removes power (`main_pwr_en`=0) and holds `main_rst_n` at 0 from the next module tick.
- R3: Status bit 0 records the wake pin. The pin passes a two-stage synchronizer clocked by the module tick and is detected on its rising edge. If the pin rises before tick k, bit 0 is set at tick k+2. While asleep, that same edge also powers the main domain up (`main_pwr_en`=1) with `main_rst_n` still 0.
- R4: Status bit 1 records a real-time-counter match. If `rtc_match` is high at a tick, bit 1 is set at that tick. While asleep, that tick also powers the main domain up with reset still held.
- R5: `main_rst_n` rises only on a module tick where `supply_good` is 1, and only after a wake or after the controller's own reset. While `supply_good` stays 0, it stays low.
- R6: Status bits set during the wake keep their value after `main_rst_n` is released.
- R7: Status bit 2 is set at any tick where `low_batt` is 1. This event never powers the main domain up.
- R8: `mask_stat` equals `raw_stat` AND `mask_reg`, and `irq` is the OR of `mask_stat`.
- R9: A write to address 1 clears each status bit whose data bit is 1 and leaves the other bits unchanged.
- R10: If a clear and a new event of the same source land on the same tick, the status bit stays set.
- R11: A wake pin held high sets bit 0 only once. After the bit is cleared, it stays clear while the pin stays high.
- R12: A write to address 0 loads the mask. Writes to any address change nothing until the next module tick after the write.
- R13: Data bit 0 of a write to address 2 selects the tick source, and the selection shows on `clk_sel`. With 0, a tick comes every DIV_RATIO cycles of `clk`. With 1, a tick comes on each rising edge of `slow_ref`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on crystal-rate clock |
| rst_n | input | 1 | Active-low reset of the controller itself |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_addr | input | 2 | 0 mask, 1 clear, 2 control |
| wr_data | input | 3 | Write data |
| slow_ref | input | 1 | 32.768 kHz reference, sampled by clk |
| wake_pin | input | 1 | External wake request, active high |
| rtc_match | input | 1 | Real-time-counter compare strobe |
| low_batt | input | 1 | Low-battery flag |
| supply_good | input | 1 | Main supply is within range |
| raw_stat | output | 3 | Raw event status (0 pin, 1 rtc, 2 battery) |
| mask_reg | output | 3 | Interrupt mask |
| mask_stat | output | 3 | Masked event status |
| irq | output | 1 | Combined interrupt request |
| clk_sel | output | 1 | Selected tick source |
| slow_tick | output | 1 | Module tick enable |
| main_pwr_en | output | 1 | Power enable for the main domain |
| main_rst_n | output | 1 | Active-low reset for the main domain |

## Verification
The properties assume that `low_batt` and `supply_good` are level signals sampled on module ticks. They also assume that `rtc_match` is held across a whole tick when it is meant to be seen, and that at most one write is outstanding between two ticks. The bench drives every input on falling clock edges and keeps event inputs high across a full tick period. It waits for a tick to be applied before it issues the next register write, so no write is ever overwritten while it waits.

// File: rtl/wake_pkg.sv
package wake_pkg;
    localparam int unsigned NUM_EV  = 3;
    localparam int unsigned EV_PIN  = 0;
    localparam int unsigned EV_RTC  = 1;
    localparam int unsigned EV_BATT = 2;

    localparam int unsigned CTRL_SEL   = 0;
    localparam int unsigned CTRL_SLEEP = 1;

    localparam logic [1:0] ADDR_MASK  = 2'd0;
    localparam logic [1:0] ADDR_CLEAR = 2'd1;
    localparam logic [1:0] ADDR_CTRL  = 2'd2;

    typedef enum logic [1:0] {
        PS_RUN     = 2'd0,
        PS_SLEEP   = 2'd1,
        PS_WAITPWR = 2'd2
    } pwr_state_e;

    typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/wake_tick_gen.sv
module wake_tick_gen #(
    parameter int unsigned DIV_RATIO = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic use_ref,
    input  logic ref_in,
    output logic tick
);
    localparam int unsigned CNT_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [2:0]       ref_sh;
    } tg_t;

    tg_t tg_d, tg_q;
    logic div_wrap;
    logic ref_rise;

    always_comb begin
        tg_d     = tg_q;
        div_wrap = (tg_q.cnt == CNT_W'(DIV_RATIO - 1));
        ref_rise = tg_q.ref_sh[1] & ~tg_q.ref_sh[2];
        tg_d.ref_sh = {tg_q.ref_sh[1:0], ref_in};
        tg_d.cnt    = div_wrap ? '0 : tg_q.cnt + 1'b1;
        tick        = use_ref ? ref_rise : div_wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tg_q <= '0;
        else        tg_q <= tg_d;
    end
endmodule

// File: rtl/wake_wr_stage.sv
module wake_wr_stage
    import wake_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  logic    wr_en,
    input  logic [1:0] wr_addr,
    input  ev_vec_t wr_data,
    output logic    apply_mask,
    output logic    apply_clear,
    output logic    apply_ctrl,
    output ev_vec_t apply_data
);
    typedef struct packed {
        logic       valid;
        logic [1:0] addr;
        ev_vec_t    data;
    } pend_t;

    pend_t pend_d, pend_q;
    logic fire;

    always_comb begin
        pend_d = pend_q;
        if (tick) pend_d.valid = 1'b0;
        if (wr_en) begin
            pend_d.valid = 1'b1;
            pend_d.addr  = wr_addr;
            pend_d.data  = wr_data;
        end
        fire        = pend_q.valid & tick;
        apply_mask  = fire && (pend_q.addr == ADDR_MASK);
        apply_clear = fire && (pend_q.addr == ADDR_CLEAR);
        apply_ctrl  = fire && (pend_q.addr == ADDR_CTRL);
        apply_data  = pend_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/wake_event_det.sv
module wake_event_det
    import wake_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  logic    wake_pin,
    input  logic    rtc_match,
    input  logic    low_batt,
    output ev_vec_t ev_set,
    output logic    wake_trig
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } pin_t;

    pin_t pin_d, pin_q;

    always_comb begin
        pin_d = pin_q;
        if (tick) begin
            pin_d.s1 = wake_pin;
            pin_d.s2 = pin_q.s1;
            pin_d.s3 = pin_q.s2;
        end
        ev_set          = '0;
        ev_set[EV_PIN]  = tick & pin_q.s2 & ~pin_q.s3;
        ev_set[EV_RTC]  = tick & rtc_match;
        ev_set[EV_BATT] = tick & low_batt;
        wake_trig       = ev_set[EV_PIN] | ev_set[EV_RTC];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_d;
    end
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
    import wake_pkg::*;
#(
    parameter int unsigned DIV_RATIO = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [2:0] wr_data,
    input  logic       slow_ref,
    input  logic       wake_pin,
    input  logic       rtc_match,
    input  logic       low_batt,
    input  logic       supply_good,
    output logic [2:0] raw_stat,
    output logic [2:0] mask_reg,
    output logic [2:0] mask_stat,
    output logic       irq,
    output logic       clk_sel,
    output logic       slow_tick,
    output logic       main_pwr_en,
    output logic       main_rst_n
);
    typedef struct packed {
        pwr_state_e state;
        ev_vec_t    raw;
        ev_vec_t    mask;
        logic       sel;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic    tick;
    logic    apply_mask, apply_clear, apply_ctrl;
    ev_vec_t apply_data;
    ev_vec_t ev_set;
    logic    wake_trig;

    wake_tick_gen #(.DIV_RATIO(DIV_RATIO)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .use_ref (ctl_q.sel),
        .ref_in  (slow_ref),
        .tick    (tick)
    );

    wake_wr_stage u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .apply_mask  (apply_mask),
        .apply_clear (apply_clear),
        .apply_ctrl  (apply_ctrl),
        .apply_data  (apply_data)
    );

    wake_event_det u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wake_pin  (wake_pin),
        .rtc_match (rtc_match),
        .low_batt  (low_batt),
        .ev_set    (ev_set),
        .wake_trig (wake_trig)
    );

    always_comb begin
        ctl_d = ctl_q;
        // clear first, then new events: a same-tick event wins
        if (apply_clear) ctl_d.raw = ctl_q.raw & ~apply_data;
        ctl_d.raw = ctl_d.raw | ev_set;
        if (apply_mask) ctl_d.mask = apply_data;
        if (apply_ctrl) ctl_d.sel = apply_data[CTRL_SEL];
        unique case (ctl_q.state)
            PS_RUN:     if (apply_ctrl && apply_data[CTRL_SLEEP]) ctl_d.state = PS_SLEEP;
            PS_SLEEP:   if (wake_trig) ctl_d.state = PS_WAITPWR;
            PS_WAITPWR: if (tick && supply_good) ctl_d.state = PS_RUN;
            default:    ctl_d.state = PS_WAITPWR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= PS_WAITPWR;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign raw_stat    = ctl_q.raw;
    assign mask_reg    = ctl_q.mask;
    assign mask_stat   = ctl_q.raw & ctl_q.mask;
    assign irq         = |mask_stat;
    assign clk_sel     = ctl_q.sel;
    assign slow_tick   = tick;
    assign main_pwr_en = (ctl_q.state != PS_SLEEP);
    assign main_rst_n  = (ctl_q.state == PS_RUN);
endmodule

// File: rtl/wake_ctrl_chk.sv
module wake_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       slow_tick,
    input logic       low_batt,
    input logic       supply_good,
    input logic [2:0] raw_stat,
    input logic [2:0] mask_reg,
    input logic       main_pwr_en,
    input logic       main_rst_n
);
    assert_sleep_holds_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !main_pwr_en |-> !main_rst_n);

    assert_powerup_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_pwr_en) |-> (raw_stat[0] || raw_stat[1]));

    assert_release_needs_supply_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_rst_n) |-> ($past(supply_good) && $past(slow_tick)));

    assert_batt_clear_loses_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(raw_stat[2]) |-> !$past(low_batt));

    assert_change_only_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(slow_tick) |-> ($stable(raw_stat) && $stable(mask_reg) && $stable(main_rst_n)));
endmodule

bind wake_ctrl wake_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slow_tick   (slow_tick),
    .low_batt    (low_batt),
    .supply_good (supply_good),
    .raw_stat    (raw_stat),
    .mask_reg    (mask_reg),
    .main_pwr_en (main_pwr_en),
    .main_rst_n  (main_rst_n)
);

// File: tb/wake_ctrl_bench.sv
module wake_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [2:0] wr_data = 3'd0;
    logic       slow_ref = 1'b0;
    logic       wake_pin = 1'b0;
    logic       rtc_match = 1'b0;
    logic       low_batt = 1'b0;
    logic       supply_good = 1'b0;
    logic [2:0] raw_stat, mask_reg, mask_stat;
    logic       irq, clk_sel, slow_tick, main_pwr_en, main_rst_n;

    wake_ctrl u_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .slow_ref(slow_ref), .wake_pin(wake_pin), .rtc_match(rtc_match),
        .low_batt(low_batt), .supply_good(supply_good), .raw_stat(raw_stat),
        .mask_reg(mask_reg), .mask_stat(mask_stat), .irq(irq), .clk_sel(clk_sel),
        .slow_tick(slow_tick), .main_pwr_en(main_pwr_en), .main_rst_n(main_rst_n)
    );

    always #4 clk = ~clk;

    typedef struct {
        string      req;
        logic [2:0] raw;
        logic [2:0] mask;
        logic       pwr;
        logic       rst;
    } exp_t;

    exp_t sb_q[$];
    int checks = 0;
    int fails  = 0;

    logic [2:0] m_raw = 3'd0;
    logic [2:0] m_mask = 3'd0;
    logic       m_pwr = 1'b1;
    logic       m_rst = 1'b0;

    // free-running 32.768 kHz stand-in: period 40 clk cycles
    initial forever begin
        repeat (20) @(negedge clk);
        slow_ref = ~slow_ref;
    end

    // monitor: pops expected items and compares them with the ports
    initial forever begin
        exp_t e;
        logic [2:0] e_ms;
        wait (sb_q.size() != 0);
        e = sb_q.pop_front();
        e_ms = e.raw & e.mask;
        checks++;
        if (raw_stat !== e.raw || mask_reg !== e.mask || mask_stat !== e_ms ||
            irq !== (|e_ms) || main_pwr_en !== e.pwr || main_rst_n !== e.rst) begin
            fails++;
            $display("FAIL %s: raw=%b mask=%b mstat=%b irq=%b pwr=%b rst=%b expected raw=%b mask=%b mstat=%b irq=%b pwr=%b rst=%b",
                     e.req, raw_stat, mask_reg, mask_stat, irq, main_pwr_en, main_rst_n,
                     e.raw, e.mask, e_ms, |e_ms, e.pwr, e.rst);
        end
    end

    task automatic expect_state(input string req);
        exp_t e;
        e.req = req; e.raw = m_raw; e.mask = m_mask; e.pwr = m_pwr; e.rst = m_rst;
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
    endtask

    task automatic check_val(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step_tick();
        @(negedge clk);
        while (slow_tick !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [1:0] a, input logic [2:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure_period(output int n);
        @(negedge clk);
        while (slow_tick !== 1'b1) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (slow_tick !== 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int per;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_state("R1");
        check_val("R1 clk_sel", int'(clk_sel), 0);

        step_tick(); step_tick();
        expect_state("R5 held without supply");
        supply_good = 1'b1;
        step_tick();
        m_rst = 1'b1;
        expect_state("R5 release");

        // R12: mask write not visible before tick
        step_tick();
        do_write(2'd0, 3'b111);
        expect_state("R12 before tick");
        step_tick();
        m_mask = 3'b111;
        expect_state("R12 after tick");

        // R7 / R8 low battery while running
        low_batt = 1'b1; step_tick(); low_batt = 1'b0;
        m_raw = 3'b100;
        expect_state("R7 R8 battery event");
        do_write(2'd1, 3'b100); step_tick();
        m_raw = 3'b000;
        expect_state("R9 clear");

        // R10 clear and event on same tick
        low_batt = 1'b1; step_tick();
        do_write(2'd1, 3'b100); step_tick();
        low_batt = 1'b0;
        m_raw = 3'b100;
        expect_state("R10 set wins");
        do_write(2'd1, 3'b011); step_tick();
        expect_state("R9 other bits untouched");
        do_write(2'd1, 3'b100); step_tick();
        m_raw = 3'b000;
        expect_state("R9 clear bit2");

        do_write(2'd0, 3'b001); step_tick();
        m_mask = 3'b001;
        expect_state("R12 mask load");

        // R2 sleep
        supply_good = 1'b0;
        do_write(2'd2, 3'b010); step_tick();
        m_pwr = 1'b0; m_rst = 1'b0;
        expect_state("R2 sleep");

        // R7 battery does not wake, R8 masked off
        low_batt = 1'b1; step_tick(); low_batt = 1'b0;
        m_raw = 3'b100;
        expect_state("R7 no wake R8 masked");
        do_write(2'd1, 3'b100); step_tick();
        m_raw = 3'b000;
        expect_state("R9 clear in sleep");

        // R3 wake pin: set on third tick
        wake_pin = 1'b1;
        step_tick(); step_tick();
        expect_state("R3 sync latency");
        step_tick();
        m_raw = 3'b001; m_pwr = 1'b1;
        expect_state("R3 wake");
        step_tick(); step_tick();
        expect_state("R5 held after wake");
        supply_good = 1'b1; step_tick();
        m_rst = 1'b1;
        expect_state("R6 cause kept after release");

        // R11 held pin sets only once
        do_write(2'd1, 3'b001); step_tick();
        m_raw = 3'b000;
        step_tick(); step_tick(); step_tick();
        expect_state("R11 held pin");
        wake_pin = 1'b0;

        // R4 rtc wake
        supply_good = 1'b0;
        do_write(2'd2, 3'b010); step_tick();
        m_pwr = 1'b0; m_rst = 1'b0;
        expect_state("R2 sleep again");
        rtc_match = 1'b1; step_tick(); rtc_match = 1'b0;
        m_raw = 3'b010; m_pwr = 1'b1;
        expect_state("R4 rtc wake");
        supply_good = 1'b1; step_tick();
        m_rst = 1'b1;
        expect_state("R6 rtc cause kept");

        // R13 tick sources
        measure_period(per);
        check_val("R13 divided period", per, 128);
        step_tick();
        do_write(2'd2, 3'b001); step_tick();
        check_val("R13 clk_sel", int'(clk_sel), 1);
        measure_period(per);
        check_val("R13 reference period", per, 40);
        expect_state("R13 state unchanged");

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule